// File: doc/BRIEF.md
# Configuration Security Gatekeeper

The block decides whether an incoming configuration stream may be loaded, and it governs access to a battery-backed key store. It never computes a cipher or a hash. An external decryptor parses each stream header and presents its flags. The flags say whether the stream is encrypted, which key source it selects, and whether it is a partial stream. The decryptor also reports the port kind, the bus width and the security level. The block checks these against the fuse control flags and its own record of what was last loaded, and registers an accept or reject decision.

After an accepted full stream, the decryptor reports whether authentication succeeded. The block then raises DONE and the end-of-startup flag. On failure it flags an authentication error and pulses INIT low. It also drives readback permission, a configuration clock halving select, and status bits.

A request to access the key store never reaches the key directly. The block first emits one cycle of clear strobes, which erase the key and configuration memory. Only after that does it grant access.

Top module: `cfg_gate`

## Requirements
- R1: When `key_acc_req` rises, the next cycle shows `key_clr` and `mem_clr` high together with `acc_grant` low. In the cycle after that the strobes are low and `acc_grant` is high, and it stays high while the request is held.
- R2: `key_loaded` is set by `key_prog` only while `acc_grant` is high. It is cleared by the clear strobe at the start of an access. A `key_prog` pulse without a grant has no effect on `key_loaded`.
- R3: When `fuse_enc_only` is 1, a full stream on an external port is accepted only if `hdr_enc`=1 and `hdr_keysel`=1 (fuse key). The internal port, `port_kind`=3, is exempt from this rule.
- R4: A full header is evaluated once. The decision holds, and further full headers are ignored, until a `por_evt` or `prog_evt` pulse. An unencrypted stream is accepted while a key is held, and the held key is left unchanged.
- R5: An encrypted stream on the slave parallel port (`port_kind`=2) or the internal port (`port_kind`=3) is rejected unless `port_width`=0 (8-bit). A width of 1 means 16-bit and a width of 2 means 32-bit.
- R6: `cclk_half` goes high in the decision cycle only for an accepted encrypted stream on the master parallel port (`port_kind`=1) at `port_width`=1.
- R7: While an accepted full stream awaits authentication, an `auth_done` pulse with `auth_ok`=1 raises `done` and end-of-startup in the next cycle.
- R8: An `auth_done` pulse with `auth_ok`=0 keeps `done` low and sets `auth_err`. It drives `init_b` low for one cycle and then high again when `fallback_en`=1. When `fallback_en`=0, `init_b` stays low until the next clear.
- R9: At `done`, `rb_en` is set only if the loaded stream was unencrypted and its `sec_lvl` was 0. It is never set after an encrypted configuration.
- R10: After `done`, a partial header from an external port is rejected when `fuse_no_ext_partial`=1 or `sec_lvl`=2. An encrypted partial stream is rejected unless the base stream was encrypted with the same key source.
- R11: `cfg_status` carries decrypt-enabled at bit 1, end-of-startup at bit 4 and DONE at bit 14. All other bits are zero.
- R12: After reset, `accept`, `reject`, `done`, `auth_err`, `rb_en`, `cclk_half`, `acc_grant` and `key_loaded` are 0, `init_b` is 1, and `cfg_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as a power-on |
| por_evt | input | 1 | Power-on event pulse, clears configuration state |
| prog_evt | input | 1 | Program-pin pulse, clears configuration state |
| hdr_valid | input | 1 | One-cycle strobe: header flags are valid |
| hdr_enc | input | 1 | Stream is encrypted |
| hdr_keysel | input | 1 | Key source: 0 battery store, 1 fuse |
| hdr_partial | input | 1 | Stream is a partial reconfiguration |
| port_kind | input | 2 | 0 master serial, 1 master parallel, 2 slave parallel, 3 internal |
| port_width | input | 2 | 0 8-bit, 1 16-bit, 2 32-bit |
| sec_lvl | input | 2 | Stream security level, 2 is the highest |
| fuse_enc_only | input | 1 | Fuse flag: external streams must be fuse-key encrypted |
| fuse_no_ext_partial | input | 1 | Fuse flag: no partial streams from external ports |
| fallback_en | input | 1 | Fallback enabled |
| auth_done | input | 1 | Decryptor finished authentication |
| auth_ok | input | 1 | Key matched and authentication passed |
| key_acc_req | input | 1 | Serial-port key store access request (level) |
| key_prog | input | 1 | Program the key store |
| accept | output | 1 | Last header decision: accepted |
| reject | output | 1 | Last header decision: rejected |
| done | output | 1 | Configuration complete |
| init_b | output | 1 | INIT status, low on error |
| auth_err | output | 1 | Authentication error status |
| rb_en | output | 1 | Configuration readback permitted |
| cclk_half | output | 1 | Configuration clock runs at half rate |
| key_clr | output | 1 | Key store clear strobe |
| mem_clr | output | 1 | Configuration memory clear strobe |
| acc_grant | output | 1 | Key store access granted |
| key_loaded | output | 1 | Key store holds a key |
| cfg_status | output | 16 | Status word |

## Verification
On every cycle the assertions check several invariants. Each grant must be preceded by a clear strobe, and the key clear must always come with a memory clear. A key can only become loaded under a grant. Accept and reject never hold together. The clock halving never appears without decryption, and readback never coexists with decryption or appears before DONE. DONE and the authentication error exclude each other, and DONE only rises after an accept.

Only the bench's scenarios can show the policy decisions themselves. These are the fuse-only and width rejections, the once-per-header hold, the partial-stream key match, the INIT pulse shape with and without fallback, and the exact status bit positions. Each of these depends on which header was presented.

// File: rtl/cfg_gate.sv
module cfg_gate #(
  parameter int STAT_W   = 16,
  parameter int DEC_BIT  = 1,
  parameter int EOS_BIT  = 4,
  parameter int DONE_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              prog_evt,
  input  logic              hdr_valid,
  input  logic              hdr_enc,
  input  logic              hdr_keysel,
  input  logic              hdr_partial,
  input  logic [1:0]        port_kind,
  input  logic [1:0]        port_width,
  input  logic [1:0]        sec_lvl,
  input  logic              fuse_enc_only,
  input  logic              fuse_no_ext_partial,
  input  logic              fallback_en,
  input  logic              auth_done,
  input  logic              auth_ok,
  input  logic              key_acc_req,
  input  logic              key_prog,
  output logic              accept,
  output logic              reject,
  output logic              done,
  output logic              init_b,
  output logic              auth_err,
  output logic              rb_en,
  output logic              cclk_half,
  output logic              key_clr,
  output logic              mem_clr,
  output logic              acc_grant,
  output logic              key_loaded,
  output logic [STAT_W-1:0] cfg_status
);
  localparam logic [1:0] PK_MPAR = 2'd1, PK_SPAR = 2'd2, PK_INT = 2'd3;
  localparam logic [1:0] PW_8 = 2'd0, PW_16 = 2'd1;
  localparam logic [1:0] SEC_TOP = 2'd2;

  logic in_acc, decided, wait_auth, fb_pend, dec_en, eos;
  logic cfg_enc, cfg_keysel;
  logic [1:0] cfg_sec;

  wire ext        = port_kind != PK_INT;
  wire acc_start  = key_acc_req && !in_acc;
  wire clr_ev     = por_evt || prog_evt || acc_start;
  wire width_ok   = !hdr_enc || !(port_kind == PK_SPAR || port_kind == PK_INT) || port_width == PW_8;
  wire fuse_ok    = !(fuse_enc_only && ext) || (hdr_enc && hdr_keysel);
  wire part_ok    = !(ext && (fuse_no_ext_partial || sec_lvl == SEC_TOP)) &&
                    (!hdr_enc || (cfg_enc && hdr_keysel == cfg_keysel));
  wire full_ev    = hdr_valid && !hdr_partial && !decided;
  wire part_ev    = hdr_valid && hdr_partial && done;
  wire full_ok    = width_ok && fuse_ok;
  wire part_pass  = full_ok && part_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_acc     <= 1'b0;
      key_clr    <= 1'b0;
      mem_clr    <= 1'b0;
      acc_grant  <= 1'b0;
      key_loaded <= 1'b0;
    end else begin
      in_acc    <= key_acc_req;
      key_clr   <= acc_start;
      mem_clr   <= clr_ev;
      acc_grant <= key_acc_req && in_acc;
      if (acc_start)                  key_loaded <= 1'b0;
      else if (acc_grant && key_prog) key_loaded <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decided <= 1'b0; accept <= 1'b0; reject <= 1'b0; wait_auth <= 1'b0;
      done <= 1'b0; eos <= 1'b0; dec_en <= 1'b0; cclk_half <= 1'b0;
      auth_err <= 1'b0; init_b <= 1'b1; fb_pend <= 1'b0; rb_en <= 1'b0;
      cfg_enc <= 1'b0; cfg_keysel <= 1'b0; cfg_sec <= 2'd0;
    end else if (clr_ev) begin
      decided <= 1'b0; accept <= 1'b0; reject <= 1'b0; wait_auth <= 1'b0;
      done <= 1'b0; eos <= 1'b0; dec_en <= 1'b0; cclk_half <= 1'b0;
      auth_err <= 1'b0; init_b <= 1'b1; fb_pend <= 1'b0; rb_en <= 1'b0;
      cfg_enc <= 1'b0; cfg_keysel <= 1'b0; cfg_sec <= 2'd0;
    end else begin
      if (full_ev) begin
        decided <= 1'b1;
        accept  <= full_ok;
        reject  <= !full_ok;
        if (full_ok) begin
          cfg_enc    <= hdr_enc;
          cfg_keysel <= hdr_keysel;
          cfg_sec    <= sec_lvl;
          dec_en     <= hdr_enc;
          cclk_half  <= hdr_enc && port_kind == PK_MPAR && port_width == PW_16;
          wait_auth  <= 1'b1;
        end
      end else if (part_ev) begin
        accept <= part_pass;
        reject <= !part_pass;
      end
      if (wait_auth && auth_done) begin
        wait_auth <= 1'b0;
        if (auth_ok) begin
          done  <= 1'b1;
          eos   <= 1'b1;
          rb_en <= !cfg_enc && cfg_sec == 2'd0;
        end else begin
          auth_err <= 1'b1;
          init_b   <= 1'b0;
          fb_pend  <= fallback_en;
        end
      end
      if (fb_pend) begin
        init_b  <= 1'b1;
        fb_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_status           = '0;
    cfg_status[DEC_BIT]  = dec_en;
    cfg_status[EOS_BIT]  = eos;
    cfg_status[DONE_BIT] = done;
  end
endmodule

// File: rtl/cfg_gate_chk.sv
module cfg_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        reject,
  input logic        done,
  input logic        auth_err,
  input logic        rb_en,
  input logic        cclk_half,
  input logic        key_clr,
  input logic        mem_clr,
  input logic        acc_grant,
  input logic        key_loaded,
  input logic [15:0] cfg_status
);
  a_r1_clear_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_grant) |-> $past(key_clr));
  a_r1_key_clr_with_mem: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr |-> mem_clr);
  a_r2_load_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_loaded) |-> $past(acc_grant));
  a_r4_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject));
  a_r6_half_needs_dec: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_half |-> cfg_status[1]);
  a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(accept));
  a_r8_done_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !auth_err);
  a_r9_rb_plain_only: assert property (@(posedge clk) disable iff (!rst_n)
    rb_en |-> (done && !cfg_status[1]));
endmodule

bind cfg_gate cfg_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .reject(reject), .done(done),
  .auth_err(auth_err), .rb_en(rb_en), .cclk_half(cclk_half), .key_clr(key_clr),
  .mem_clr(mem_clr), .acc_grant(acc_grant), .key_loaded(key_loaded),
  .cfg_status(cfg_status)
);

// File: tb/cfg_gate_bench.sv
module cfg_gate_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic por_evt = 0, prog_evt = 0, hdr_valid = 0, hdr_enc = 0, hdr_keysel = 0, hdr_partial = 0;
  logic [1:0] port_kind = 0, port_width = 0, sec_lvl = 0;
  logic fuse_enc_only = 0, fuse_no_ext_partial = 0, fallback_en = 0;
  logic auth_done = 0, auth_ok = 0, key_acc_req = 0, key_prog = 0;
  logic accept, reject, done, init_b, auth_err, rb_en, cclk_half;
  logic key_clr, mem_clr, acc_grant, key_loaded;
  logic [15:0] cfg_status;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_gate u_cfg_gate (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic prog();
    cyc(); prog_evt = 1; cyc(); prog_evt = 0;
  endtask

  task automatic hdr(input logic enc, input logic ksel, input logic part,
                     input logic [1:0] kind, input logic [1:0] wid, input logic [1:0] sec);
    cyc();
    hdr_valid = 1; hdr_enc = enc; hdr_keysel = ksel; hdr_partial = part;
    port_kind = kind; port_width = wid; sec_lvl = sec;
    cyc();
    hdr_valid = 0;
  endtask

  task automatic auth(input logic ok);
    cyc(); auth_done = 1; auth_ok = ok; cyc(); auth_done = 0;
  endtask

  task automatic t_reset();
    chk("R12 accept", accept, 0); chk("R12 reject", reject, 0);
    chk("R12 done", done, 0); chk("R12 init_b", init_b, 1);
    chk("R12 auth_err", auth_err, 0); chk("R12 rb_en", rb_en, 0);
    chk("R12 cclk_half", cclk_half, 0); chk("R12 grant", acc_grant, 0);
    chk("R12 key_loaded", key_loaded, 0); chk("R12 status", cfg_status, 0);
  endtask

  task automatic t_key_access();
    cyc(); key_prog = 1; cyc(); key_prog = 0;
    chk("R2 prog without grant", key_loaded, 0);
    cyc(); key_acc_req = 1; cyc();
    chk("R1 key_clr", key_clr, 1); chk("R1 mem_clr", mem_clr, 1); chk("R1 no grant yet", acc_grant, 0);
    cyc();
    chk("R1 key_clr off", key_clr, 0); chk("R1 grant", acc_grant, 1);
    key_prog = 1; cyc(); key_prog = 0;
    chk("R2 key loaded", key_loaded, 1); chk("R1 grant held", acc_grant, 1);
    key_acc_req = 0; cyc();
    chk("R1 grant drops", acc_grant, 0);
  endtask

  task automatic t_plain_with_key();
    prog();
    hdr(0, 0, 0, 2'd0, 2'd0, 2'd0);
    chk("R4 plain accepted with key", accept, 1);
    auth(1);
    chk("R7 done", done, 1); chk("R9 readback plain", rb_en, 1);
    chk("R11 status plain", cfg_status, 16'h4010);
    chk("R4 key unchanged", key_loaded, 1);
    hdr(1, 0, 0, 2'd2, 2'd1, 2'd0);
    chk("R4 second header ignored accept", accept, 1);
    chk("R4 second header ignored reject", reject, 0);
    prog();
    hdr(0, 0, 0, 2'd0, 2'd0, 2'd1);
    auth(1);
    chk("R9 readback blocked by level", rb_en, 0);
  endtask

  task automatic t_encrypted();
    prog();
    hdr(1, 0, 0, 2'd0, 2'd0, 2'd0);
    chk("R11 status dec", cfg_status, 16'h0002);
    auth(1);
    chk("R11 status enc done", cfg_status, 16'h4012);
    chk("R9 no readback encrypted", rb_en, 0);
  endtask

  task automatic t_width();
    prog(); hdr(1, 0, 0, 2'd2, 2'd1, 2'd0);
    chk("R5 slave x16 enc reject", reject, 1);
    prog(); hdr(1, 0, 0, 2'd3, 2'd2, 2'd0);
    chk("R5 internal x32 enc reject", reject, 1);
    prog(); hdr(1, 0, 0, 2'd2, 2'd0, 2'd0);
    chk("R5 slave x8 enc accept", accept, 1);
    prog(); hdr(0, 0, 0, 2'd2, 2'd2, 2'd0);
    chk("R5 slave x32 plain accept", accept, 1);
  endtask

  task automatic t_cclk();
    prog(); hdr(1, 0, 0, 2'd1, 2'd1, 2'd0);
    chk("R6 half on enc mpar x16", cclk_half, 1);
    prog(); hdr(0, 0, 0, 2'd1, 2'd1, 2'd0);
    chk("R6 no half plain", cclk_half, 0);
    prog(); hdr(1, 0, 0, 2'd1, 2'd0, 2'd0);
    chk("R6 no half x8", cclk_half, 0);
  endtask

  task automatic t_fuse();
    fuse_enc_only = 1;
    prog(); hdr(0, 0, 0, 2'd0, 2'd0, 2'd0);
    chk("R3 plain external reject", reject, 1);
    prog(); hdr(1, 0, 0, 2'd0, 2'd0, 2'd0);
    chk("R3 battery key reject", reject, 1);
    prog(); hdr(1, 1, 0, 2'd0, 2'd0, 2'd0);
    chk("R3 fuse key accept", accept, 1);
    prog(); hdr(0, 0, 0, 2'd3, 2'd0, 2'd0);
    chk("R3 internal exempt", accept, 1);
    fuse_enc_only = 0;
  endtask

  task automatic t_auth_fail();
    fallback_en = 1;
    prog(); hdr(1, 0, 0, 2'd0, 2'd0, 2'd0);
    auth(0);
    chk("R8 done low", done, 0); chk("R8 auth_err", auth_err, 1);
    chk("R8 init low", init_b, 0);
    cyc();
    chk("R8 init back high", init_b, 1);
    fallback_en = 0;
    prog();
    chk("R8 err cleared", auth_err, 0);
    hdr(1, 0, 0, 2'd0, 2'd0, 2'd0);
    auth(0);
    cyc(); cyc(); cyc();
    chk("R8 init stays low", init_b, 0);
  endtask

  task automatic t_partial();
    prog(); hdr(1, 0, 0, 2'd0, 2'd0, 2'd0); auth(1);
    hdr(1, 0, 1, 2'd0, 2'd0, 2'd0);
    chk("R10 same key partial", accept, 1);
    hdr(1, 1, 1, 2'd0, 2'd0, 2'd0);
    chk("R10 other key partial", reject, 1);
    chk("R10 done kept", done, 1);
    hdr(0, 0, 1, 2'd3, 2'd0, 2'd0);
    chk("R10 internal plain partial", accept, 1);
    hdr(1, 0, 1, 2'd0, 2'd0, 2'd2);
    chk("R10 top level external", reject, 1);
    fuse_no_ext_partial = 1;
    hdr(1, 0, 1, 2'd0, 2'd0, 2'd0);
    chk("R10 fuse blocks external", reject, 1);
    hdr(1, 0, 1, 2'd3, 2'd0, 2'd0);
    chk("R10 internal allowed", accept, 1);
    fuse_no_ext_partial = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_key_access();
    t_plain_with_key();
    t_encrypted();
    t_width();
    t_cclk();
    t_fuse();
    t_auth_fail();
    t_partial();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule